// File: doc/BRIEF.md
# Power-On Strap Sampling Sequencer

This block runs the dual-purpose pins of a clock generator when power comes up. Five pins can carry clocks, but an external pull resistor on each pin also gives it a configuration level. After the supply-good input rises, the block holds all five output drivers disabled for a fixed number of reference-clock cycles. During that time the resistors settle the pin levels. On the last cycle of the window, the block captures the five levels as a three-bit frequency code, a mode bit and a memory-clock source bit. It then enables the drivers, so the pins carry clocks from then on.

The captured configuration stays in place until the supply drops. No other reset clears it. After capture, the block also gives the frequency code that downstream logic should use. A control input picks one of two sources for that code: the strapped value or a code written by software. The chosen code goes to a register. Each time the code changes, the block raises a one-cycle pulse so that the synthesizer can ramp smoothly to the new frequency. Code 110 is the fastest setting. Only the high-performance build accepts it.

Top module: `strap_sequencer`

## Requirements
- R1: While `supply_ok` is low, every output is 0: `pin_oe`, `strap_done`, `strap_fs`, `strap_mode`, `strap_sdsel`, `freq_sel` (code 000), `freq_chg` and `freq_valid`.
- R2: After `supply_ok` rises, `pin_oe` stays all-zero for exactly `WINDOW_CYC - 1` rising edges. At rising edge number `WINDOW_CYC`, all five bits of `pin_oe` become 1 together with `strap_done`, and they stay 1.
- R3: At rising edge number `WINDOW_CYC`, the block captures `pin_in`. The mapping is: `strap_fs` = `pin_in[2:0]` (bit 0 from the 24 MHz pin, bit 1 from the 48 MHz pin, bit 2 from the free-running PCI pin), `strap_mode` = `pin_in[3]` (free-running AGP pin) and `strap_sdsel` = `pin_in[4]` (reference pin).
- R4: After capture, changes on `pin_in` leave `strap_fs`, `strap_mode` and `strap_sdsel` unchanged.
- R5: A drop of `supply_ok` clears the captured straps and `strap_done`. The next rise of `supply_ok` starts a new full window.
- R6: One rising edge after `strap_done` rises, `freq_valid` becomes 1. At the same edge, `freq_sel` takes `cfg_sel` if `cfg_override` is 1, or `strap_fs` if it is 0.
- R7: After that edge, a change of `cfg_override` or `cfg_sel` appears on `freq_sel` at the next rising edge.
- R8: When `HIGH_PERF` = 0, a requested code 110 is ignored and `freq_sel` keeps its previous value. When `HIGH_PERF` = 1, code 110 is accepted like any other code.
- R9: `freq_chg` is 1 for exactly the one cycle in which `freq_sel` holds a new value. It stays 0 when the selected code equals the current one.
- R10: Before `strap_done` rises, `cfg_override` and `cfg_sel` have no effect, and `freq_sel` stays 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| supply_ok | input | 1 | Supply-good indication; low acts as the only reset |
| pin_in | input | 5 | Levels sensed on the five shared pins |
| cfg_override | input | 1 | 1 selects `cfg_sel` as the frequency code |
| cfg_sel | input | 3 | Frequency code from the register field |
| pin_oe | output | 5 | Driver enables for the five shared pins |
| strap_done | output | 1 | Window finished and straps captured |
| strap_fs | output | 3 | Captured frequency code |
| strap_mode | output | 1 | Captured mode bit |
| strap_sdsel | output | 1 | Captured memory-clock source bit |
| freq_sel | output | 3 | Effective registered frequency code |
| freq_chg | output | 1 | One-cycle pulse on a change of `freq_sel` |
| freq_valid | output | 1 | `freq_sel` holds a selected code |

## Verification
The bench builds the standard variant as `uut` with `WINDOW_CYC` = 20. This short window lets the test count every edge of the window and check the exact cycle of capture. It also leaves room for several power cycles within the run. A second copy built with `HIGH_PERF` = 1 gets the same stimulus. Code 110 can therefore be seen rejected by one copy and accepted by the other under identical inputs.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;

    localparam int NUM_PINS   = 5;
    localparam int FS_W       = 3;
    localparam int PIN_FS_LSB = 0;
    localparam int PIN_MODE   = 3;
    localparam int PIN_SDSEL  = 4;

    typedef struct packed {
        logic [FS_W-1:0] fs;
        logic            mode;
        logic            sdsel;
    } straps_t;

    localparam straps_t STRAPS_CLEAR = '{fs: '0, mode: 1'b0, sdsel: 1'b0};

endpackage

// File: rtl/strap_window_timer.sv
module strap_window_timer #(
    parameter int WINDOW_CYC = 28636
) (
    input  logic clk,
    input  logic supply_ok,
    output logic last_cyc,
    output logic done
);

    localparam int CW = $clog2(WINDOW_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(WINDOW_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!tmr_q.done) begin
            if (tmr_q.cnt == LAST) begin
                tmr_d.done = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge supply_ok) begin
        if (!supply_ok) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign last_cyc = !tmr_q.done && (tmr_q.cnt == LAST);
    assign done     = tmr_q.done;

    // R2: the window never runs past its last count
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!supply_ok)
        tmr_q.cnt <= LAST);

    // R2: completion follows the last count of the window
    a_r2_done_after_last: assert property (@(posedge clk) disable iff (!supply_ok)
        $rose(tmr_q.done) |-> $past(tmr_q.cnt) == LAST);

    // R2: completion is sticky until the supply drops
    a_r2_done_sticky: assert property (@(posedge clk) disable iff (!supply_ok)
        tmr_q.done |=> tmr_q.done);

endmodule

// File: rtl/strap_capture.sv
module strap_capture
    import strap_seq_pkg::*;
(
    input  logic                clk,
    input  logic                supply_ok,
    input  logic                capture,
    input  logic [NUM_PINS-1:0] pins,
    output straps_t             straps
);

    straps_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (capture) begin
            cap_d.fs    = pins[PIN_FS_LSB +: FS_W];
            cap_d.mode  = pins[PIN_MODE];
            cap_d.sdsel = pins[PIN_SDSEL];
        end
    end

    always_ff @(posedge clk or negedge supply_ok) begin
        if (!supply_ok) begin
            cap_q <= STRAPS_CLEAR;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign straps = cap_q;

    // R4: without a capture strobe the latched levels do not move
    a_r4_hold_no_capture: assert property (@(posedge clk) disable iff (!supply_ok)
        !capture |=> $stable(cap_q));

endmodule

// File: rtl/freq_select.sv
module freq_select
    import strap_seq_pkg::*;
#(
    parameter bit HIGH_PERF = 1'b0
) (
    input  logic            clk,
    input  logic            supply_ok,
    input  logic            enable,
    input  logic            override,
    input  logic [FS_W-1:0] reg_code,
    input  logic [FS_W-1:0] strap_code,
    output logic [FS_W-1:0] code,
    output logic            changed,
    output logic            valid
);

    localparam logic [FS_W-1:0] TOP_CODE = FS_W'(3'b110);

    typedef struct packed {
        logic [FS_W-1:0] code;
        logic            changed;
        logic            valid;
    } fsel_t;

    fsel_t fsel_d, fsel_q;
    logic [FS_W-1:0] req;
    logic            allowed;

    assign req = override ? reg_code : strap_code;

    generate
        if (HIGH_PERF) begin : g_all_codes
            assign allowed = 1'b1;
        end else begin : g_std_codes
            assign allowed = (req != TOP_CODE);
        end
    endgenerate

    always_comb begin
        fsel_d         = fsel_q;
        fsel_d.changed = 1'b0;
        if (enable) begin
            fsel_d.valid = 1'b1;
            if (allowed) begin
                fsel_d.code    = req;
                fsel_d.changed = (req != fsel_q.code);
            end
        end
    end

    always_ff @(posedge clk or negedge supply_ok) begin
        if (!supply_ok) begin
            fsel_q <= '0;
        end else begin
            fsel_q <= fsel_d;
        end
    end

    assign code    = fsel_q.code;
    assign changed = fsel_q.changed;
    assign valid   = fsel_q.valid;

    // R9: a pulse always marks a new code
    a_r9_pulse_means_change: assert property (@(posedge clk) disable iff (!supply_ok)
        fsel_q.changed |-> fsel_q.code != $past(fsel_q.code));

    // R9: a code never moves silently
    a_r9_no_silent_change: assert property (@(posedge clk) disable iff (!supply_ok)
        !fsel_q.changed |-> $stable(fsel_q.code));

    // R8: the standard build never presents the top code
    a_r8_top_code_blocked: assert property (@(posedge clk) disable iff (!supply_ok)
        !HIGH_PERF |-> fsel_q.code != TOP_CODE);

    // R10: nothing is selected before the window closes
    a_r10_idle_before_enable: assert property (@(posedge clk) disable iff (!supply_ok)
        !fsel_q.valid |-> fsel_q.code == '0);

endmodule

// File: rtl/strap_sequencer.sv
module strap_sequencer
    import strap_seq_pkg::*;
#(
    parameter int WINDOW_CYC = 28636,
    parameter bit HIGH_PERF  = 1'b0
) (
    input  logic                clk,
    input  logic                supply_ok,
    input  logic [4:0]          pin_in,
    input  logic                cfg_override,
    input  logic [2:0]          cfg_sel,
    output logic [4:0]          pin_oe,
    output logic                strap_done,
    output logic [2:0]          strap_fs,
    output logic                strap_mode,
    output logic                strap_sdsel,
    output logic [2:0]          freq_sel,
    output logic                freq_chg,
    output logic                freq_valid
);

    logic    last_cyc;
    logic    done;
    straps_t straps;

    strap_window_timer #(.WINDOW_CYC(WINDOW_CYC)) u_timer (
        .clk       (clk),
        .supply_ok (supply_ok),
        .last_cyc  (last_cyc),
        .done      (done)
    );

    strap_capture u_capture (
        .clk       (clk),
        .supply_ok (supply_ok),
        .capture   (last_cyc),
        .pins      (pin_in),
        .straps    (straps)
    );

    freq_select #(.HIGH_PERF(HIGH_PERF)) u_fsel (
        .clk        (clk),
        .supply_ok  (supply_ok),
        .enable     (done),
        .override   (cfg_override),
        .reg_code   (cfg_sel),
        .strap_code (straps.fs),
        .code       (freq_sel),
        .changed    (freq_chg),
        .valid      (freq_valid)
    );

    assign pin_oe      = {NUM_PINS{done}};
    assign strap_done  = done;
    assign strap_fs    = straps.fs;
    assign strap_mode  = straps.mode;
    assign strap_sdsel = straps.sdsel;

    // R3: captured levels equal the pins at the closing edge
    a_r3_capture_map: assert property (@(posedge clk) disable iff (!supply_ok)
        $rose(done) |-> (straps.fs == $past(pin_in[2:0])) && (straps.mode == $past(pin_in[3]))
                        && (straps.sdsel == $past(pin_in[4])));

    // R4: straps are frozen once captured
    a_r4_straps_frozen: assert property (@(posedge clk) disable iff (!supply_ok)
        done && $past(done) |-> $stable(straps));

    // R6: selection becomes valid one edge after the window closes
    a_r6_valid_follows_done: assert property (@(posedge clk) disable iff (!supply_ok)
        $rose(done) |=> freq_valid);

endmodule

// File: tb/strap_sequencer_test.sv
module strap_sequencer_test;

    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 20;

    logic       clk = 1'b0;
    logic       supply_ok = 1'b0;
    logic [4:0] pin_in = '0;
    logic       cfg_override = 1'b0;
    logic [2:0] cfg_sel = '0;

    logic [4:0] pin_oe, pin_oe_hp;
    logic       strap_done, strap_done_hp;
    logic [2:0] strap_fs, strap_fs_hp;
    logic       strap_mode, strap_mode_hp;
    logic       strap_sdsel, strap_sdsel_hp;
    logic [2:0] freq_sel, freq_sel_hp;
    logic       freq_chg, freq_chg_hp;
    logic       freq_valid, freq_valid_hp;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strap_sequencer #(.WINDOW_CYC(WIN), .HIGH_PERF(1'b0)) uut (
        .clk(clk), .supply_ok(supply_ok), .pin_in(pin_in),
        .cfg_override(cfg_override), .cfg_sel(cfg_sel),
        .pin_oe(pin_oe), .strap_done(strap_done), .strap_fs(strap_fs),
        .strap_mode(strap_mode), .strap_sdsel(strap_sdsel),
        .freq_sel(freq_sel), .freq_chg(freq_chg), .freq_valid(freq_valid)
    );

    strap_sequencer #(.WINDOW_CYC(WIN), .HIGH_PERF(1'b1)) uut_hp (
        .clk(clk), .supply_ok(supply_ok), .pin_in(pin_in),
        .cfg_override(cfg_override), .cfg_sel(cfg_sel),
        .pin_oe(pin_oe_hp), .strap_done(strap_done_hp), .strap_fs(strap_fs_hp),
        .strap_mode(strap_mode_hp), .strap_sdsel(strap_sdsel_hp),
        .freq_sel(freq_sel_hp), .freq_chg(freq_chg_hp), .freq_valid(freq_valid_hp)
    );

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic t_reset;
        supply_ok = 1'b0; pin_in = 5'b01101; cfg_override = 1'b1; cfg_sel = 3'b101;
        tick(2);
        chk("R1 pin_oe", 8'(pin_oe), 8'h00);
        chk("R1 strap_done", 8'(strap_done), 8'h0);
        chk("R1 straps", 8'({strap_fs, strap_mode, strap_sdsel}), 8'h00);
        chk("R1 freq_sel", 8'(freq_sel), 8'h0);
        chk("R1 chg/valid", 8'({freq_chg, freq_valid}), 8'h0);
    endtask

    task automatic t_window;
        pin_in = 5'b00000; cfg_override = 1'b1; cfg_sel = 3'b101;
        supply_ok = 1'b1;
        tick(WIN - 2);
        pin_in = 5'b11011;
        chk("R10 freq_sel during window", 8'(freq_sel), 8'h0);
        tick(1);
        chk("R2 pin_oe before last edge", 8'(pin_oe), 8'h00);
        chk("R2 done before last edge", 8'(strap_done), 8'h0);
        chk("R10 freq_valid during window", 8'(freq_valid), 8'h0);
        cfg_override = 1'b0;
        tick(1);
        chk("R2 pin_oe at window end", 8'(pin_oe), 8'h1f);
        chk("R2 done at window end", 8'(strap_done), 8'h1);
        chk("R3 strap_fs", 8'(strap_fs), 8'h3);
        chk("R3 strap_mode", 8'(strap_mode), 8'h1);
        chk("R3 strap_sdsel", 8'(strap_sdsel), 8'h1);
        chk("R6 not yet valid", 8'(freq_valid), 8'h0);
        tick(1);
        chk("R6 freq_sel from straps", 8'(freq_sel), 8'h3);
        chk("R6 freq_valid", 8'(freq_valid), 8'h1);
        chk("R9 pulse on first code", 8'(freq_chg), 8'h1);
        tick(1);
        chk("R9 pulse ends", 8'(freq_chg), 8'h0);
        chk("R2 pin_oe stays", 8'(pin_oe), 8'h1f);
    endtask

    task automatic t_hold;
        pin_in = 5'b00100;
        tick(3);
        chk("R4 straps held", 8'({strap_fs, strap_mode, strap_sdsel}), 8'({3'b011, 1'b1, 1'b1}));
        chk("R4 freq_sel held", 8'(freq_sel), 8'h3);
    endtask

    task automatic t_override;
        cfg_override = 1'b1; cfg_sel = 3'b101;
        tick(1);
        chk("R7 override code", 8'(freq_sel), 8'h5);
        chk("R9 override pulse", 8'(freq_chg), 8'h1);
        tick(1);
        chk("R9 single pulse", 8'(freq_chg), 8'h0);
        tick(1);
        chk("R9 no pulse same code", 8'(freq_chg), 8'h0);
        chk("R7 code kept", 8'(freq_sel), 8'h5);
        cfg_override = 1'b0;
        tick(1);
        chk("R7 back to straps", 8'(freq_sel), 8'h3);
        chk("R9 pulse on return", 8'(freq_chg), 8'h1);
    endtask

    task automatic t_reject;
        cfg_override = 1'b1; cfg_sel = 3'b110;
        tick(1);
        chk("R8 std ignores 110", 8'(freq_sel), 8'h3);
        chk("R8 std no pulse", 8'(freq_chg), 8'h0);
        chk("R8 hp accepts 110", 8'(freq_sel_hp), 8'h6);
        chk("R8 hp pulse", 8'(freq_chg_hp), 8'h1);
        tick(2);
        chk("R8 std still held", 8'(freq_sel), 8'h3);
    endtask

    task automatic t_power_cycle;
        supply_ok = 1'b0;
        tick(1);
        chk("R5 cleared done", 8'(strap_done), 8'h0);
        chk("R5 cleared straps", 8'({strap_fs, strap_mode, strap_sdsel}), 8'h00);
        chk("R5 cleared pin_oe", 8'(pin_oe), 8'h00);
        pin_in = 5'b00000; cfg_override = 1'b0;
        supply_ok = 1'b1;
        tick(WIN - 1);
        chk("R5 full window again", 8'(strap_done), 8'h0);
        tick(1);
        chk("R5 done after new window", 8'(strap_done), 8'h1);
        chk("R5 new straps", 8'({strap_fs, strap_mode, strap_sdsel}), 8'h00);
        tick(1);
        chk("R6 code 000 selected", 8'(freq_sel), 8'h0);
        chk("R9 no pulse equal to reset code", 8'(freq_chg), 8'h0);
        chk("R6 valid again", 8'(freq_valid), 8'h1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_window();
        t_hold();
        t_override();
        t_reject();
        t_power_cycle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule